// File: doc/BRIEF.md
# Parametric Stimulus Waveform Generator

This block produces a stream of stimulus words from a chosen pattern instead of from stored vectors. Each cycle in which the enable input is high, the block produces one new sample and marks it with a valid flag on the next cycle. There are five patterns: a constant word, a ramp that stops at a programmed bound, a periodic pulse, pseudo-random data, and a clock-like square wave with programmable rise and fall positions inside a programmed period.

Configuration is held on plain input ports. The block samples the pattern select when a run starts. A run starts on the first enabled cycle after reset, and again on the first enabled cycle after the select input differs from the pattern now running. That first cycle loads the pattern's starting point. Each later enabled cycle advances the pattern by one step, and a cycle with enable low freezes it.

Top module: `wavegen_top`

## Requirements
- R1: While reset is asserted and directly after it, `out_valid` and `ramp_done` are 0.
- R2: `out_valid` equals the value `en` had on the previous clock edge.
- R3: With pattern code 0 running, `out_data` equals the live `const_val`.
- R4: With pattern code 1 and `ramp_down` = 0, the first sample of a run is `ramp_from`. Each further enabled cycle adds `ramp_step`.
- R5: A ramp step that would reach or cross `ramp_to` (unsigned overflow included) yields exactly `ramp_to`. From then on `ramp_done` is 1 and the output holds until the next run.
- R6: With `ramp_down` = 1, each enabled cycle subtracts `ramp_step`, and the output clamps at `ramp_to` (unsigned borrow included).
- R7: With pattern code 2, a phase counter starts at 0 and advances by one per enabled cycle, wrapping after `period`-1 (a period of 0 acts as 1). The output is `pulse_val` while phase < `high_cnt` and 0 otherwise.
- R8: With pattern code 3, the first sample is `seed`. Each step shifts the word right by one and XORs in mask 0xB400 (16-bit width) when the bit shifted out was 1.
- R9: A `seed` of 0 is replaced by the value 1.
- R10: With pattern code 4, the output is all ones while `rise_at` <= phase < `fall_at` and 0 otherwise, using the same phase counter as R7.
- R11: A changed pattern select takes effect only on the next enabled cycle, which restarts the run. With `en` low, the running pattern and its output do not change.
- R12: Pattern codes 5 to 7 output 0. `ramp_done` is 0 whenever the running pattern is not code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Produce one sample this cycle |
| mode | input | 3 | Pattern select (0 const, 1 ramp, 2 pulse, 3 random, 4 clock) |
| const_val | input | WIDTH | Constant pattern value |
| ramp_from | input | WIDTH | Ramp start value |
| ramp_to | input | WIDTH | Ramp bound |
| ramp_step | input | WIDTH | Ramp step size |
| ramp_down | input | 1 | 1 = ramp decrements |
| pulse_val | input | WIDTH | Active value of the pulse pattern |
| seed | input | WIDTH | Random pattern seed |
| period | input | CNT_W | Phase period in enabled cycles |
| high_cnt | input | CNT_W | Pulse active length |
| rise_at | input | CNT_W | Clock pattern rising phase |
| fall_at | input | CNT_W | Clock pattern falling phase |
| out_valid | output | 1 | Sample valid |
| out_data | output | WIDTH | Sample |
| ramp_done | output | 1 | Ramp has reached its bound |

## Verification
The bench builds the block with a 16-bit sample width, which is the width where the random mask of R8 applies, and an 8-bit phase counter. With these values, clamping on unsigned overflow can be reached from a start near 0xFFF0, and short periods of 5 and 6 wrap several times within a few dozen cycles. The zero period, the zero seed and the unused codes 5 to 7 are each reached directly.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;

    typedef enum logic [2:0] {
        WG_CONST  = 3'd0,
        WG_RAMP   = 3'd1,
        WG_PULSE  = 3'd2,
        WG_RANDOM = 3'd3,
        WG_CLOCK  = 3'd4
    } wg_mode_e;

    typedef struct packed {
        logic [2:0] mode;
        logic       primed;
        logic       valid;
    } wg_ctrl_t;

    // Galois feedback masks for maximal-length sequences (right shift)
    function automatic logic [63:0] wg_lfsr_taps(input int w);
        case (w)
            8:       return 64'h0000_0000_0000_00B8;
            16:      return 64'h0000_0000_0000_B400;
            24:      return 64'h0000_0000_00E1_0000;
            32:      return 64'h0000_0000_8020_0003;
            default: return (64'h1 << (w - 1)) | 64'h1;
        endcase
    endfunction

endpackage

// File: rtl/wavegen_ramp.sv
module wavegen_ramp #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         adv,
    input  logic [W-1:0] from_val,
    input  logic [W-1:0] to_val,
    input  logic [W-1:0] step_val,
    input  logic         down,
    output logic [W-1:0] value,
    output logic         done
);

    typedef struct packed {
        logic [W-1:0] cur;
        logic         done;
    } ramp_st_t;

    ramp_st_t st_d, st_q;
    logic [W:0] sum_w, dif_w;
    logic [W-1:0] nxt;

    always_comb begin
        sum_w = {1'b0, st_q.cur} + {1'b0, step_val};
        dif_w = {1'b0, st_q.cur} - {1'b0, step_val};
        if (down) begin
            nxt = (dif_w[W] || dif_w[W-1:0] <= to_val) ? to_val : dif_w[W-1:0];
        end else begin
            nxt = (sum_w >= {1'b0, to_val}) ? to_val : sum_w[W-1:0];
        end
        st_d = st_q;
        if (load) begin
            st_d.cur  = from_val;
            st_d.done = (from_val == to_val);
        end else if (adv && !st_q.done) begin
            st_d.cur  = nxt;
            st_d.done = (nxt == to_val);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.cur;
    assign done  = st_q.done;

endmodule

// File: rtl/wavegen_lfsr.sv
module wavegen_lfsr
    import wavegen_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         adv,
    input  logic [W-1:0] seed,
    output logic [W-1:0] value
);

    localparam logic [63:0]  TAPS_ALL = wg_lfsr_taps(W);
    localparam logic [W-1:0] MASK     = TAPS_ALL[W-1:0];
    localparam logic [W-1:0] SAFE     = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (load) begin
            lfsr_d = (seed == '0) ? SAFE : seed;
        end else if (adv) begin
            lfsr_d = (lfsr_q >> 1) ^ (lfsr_q[0] ? MASK : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SAFE;
        else        lfsr_q <= lfsr_d;
    end

    assign value = lfsr_q;

endmodule

// File: rtl/wavegen_phase.sv
module wavegen_phase #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] phase
);

    logic [CW-1:0] ph_d, ph_q;
    logic [CW:0]   inc_w;

    always_comb begin
        inc_w = {1'b0, ph_q} + 1'b1;
        ph_d  = ph_q;
        if (load) begin
            ph_d = '0;
        end else if (adv) begin
            ph_d = (inc_w >= {1'b0, period}) ? '0 : inc_w[CW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign phase = ph_q;

endmodule

// File: rtl/wavegen_top.sv
module wavegen_top
    import wavegen_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [2:0]       mode,
    input  logic [WIDTH-1:0] const_val,
    input  logic [WIDTH-1:0] ramp_from,
    input  logic [WIDTH-1:0] ramp_to,
    input  logic [WIDTH-1:0] ramp_step,
    input  logic             ramp_down,
    input  logic [WIDTH-1:0] pulse_val,
    input  logic [WIDTH-1:0] seed,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] high_cnt,
    input  logic [CNT_W-1:0] rise_at,
    input  logic [CNT_W-1:0] fall_at,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    output logic             ramp_done
);

    wg_ctrl_t ctrl_d, ctrl_q;
    logic restart, advance;
    logic [2:0]       act_mode;
    logic [WIDTH-1:0] ramp_v, rand_v;
    logic             ramp_fin;
    logic [CNT_W-1:0] phase;

    always_comb begin
        restart = en && (!ctrl_q.primed || (mode != ctrl_q.mode));
        advance = en && !restart;
        ctrl_d  = ctrl_q;
        ctrl_d.valid = en;
        if (restart) begin
            ctrl_d.mode   = mode;
            ctrl_d.primed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign act_mode = ctrl_q.mode;

    wavegen_ramp #(.W(WIDTH)) ramp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (restart),
        .adv      (advance),
        .from_val (ramp_from),
        .to_val   (ramp_to),
        .step_val (ramp_step),
        .down     (ramp_down),
        .value    (ramp_v),
        .done     (ramp_fin)
    );

    wavegen_lfsr #(.W(WIDTH)) lfsr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (restart),
        .adv   (advance),
        .seed  (seed),
        .value (rand_v)
    );

    wavegen_phase #(.CW(CNT_W)) phase_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (restart),
        .adv    (advance),
        .period (period),
        .phase  (phase)
    );

    always_comb begin
        case (act_mode)
            WG_CONST:  out_data = const_val;
            WG_RAMP:   out_data = ramp_v;
            WG_PULSE:  out_data = (phase < high_cnt) ? pulse_val : '0;
            WG_RANDOM: out_data = rand_v;
            WG_CLOCK:  out_data = (phase >= rise_at && phase < fall_at) ? '1 : '0;
            default:   out_data = '0;
        endcase
    end

    assign out_valid = ctrl_q.valid;
    assign ramp_done = ramp_fin && (act_mode == WG_RAMP);

endmodule

// File: rtl/wavegen_top_chk.sv
module wavegen_top_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic [2:0]   mode,
    input logic [2:0]   act_mode,
    input logic [W-1:0] pulse_val,
    input logic         out_valid,
    input logic [W-1:0] out_data,
    input logic         ramp_done
);

    // R2
    valid_tracks_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !out_valid);

    // R5
    ramp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_done && en && mode == act_mode) |=> (ramp_done && $stable(out_data)));

    // R11
    stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && (act_mode == 3'd1 || act_mode == 3'd3)) |=> $stable(out_data));

    // R12
    done_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_done |-> act_mode == 3'd1);

    // R7
    pulse_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == 3'd2) |-> (out_data == pulse_val || out_data == '0));

    // R10
    clock_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == 3'd4) |-> (out_data == '1 || out_data == '0));

    // R9
    rand_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == 3'd3 && out_valid) |-> out_data != '0);

endmodule

bind wavegen_top wavegen_top_chk #(.W(WIDTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .mode      (mode),
    .act_mode  (act_mode),
    .pulse_val (pulse_val),
    .out_valid (out_valid),
    .out_data  (out_data),
    .ramp_done (ramp_done)
);

// File: tb/wavegen_top_test.sv
`timescale 1ns/1ps
module wavegen_top_test;

    localparam int W  = 16;
    localparam int CW = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, en, ramp_down;
    logic [2:0]    mode;
    logic [W-1:0]  const_val, ramp_from, ramp_to, ramp_step, pulse_val, seed;
    logic [CW-1:0] period, high_cnt, rise_at, fall_at;
    logic          out_valid, ramp_done;
    logic [W-1:0]  out_data;

    wavegen_top #(.WIDTH(W), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
        .const_val(const_val), .ramp_from(ramp_from), .ramp_to(ramp_to),
        .ramp_step(ramp_step), .ramp_down(ramp_down), .pulse_val(pulse_val),
        .seed(seed), .period(period), .high_cnt(high_cnt), .rise_at(rise_at),
        .fall_at(fall_at), .out_valid(out_valid), .out_data(out_data),
        .ramp_done(ramp_done)
    );

    int n_tests = 0;
    int n_fail  = 0;
    string req = "R1";

    // behavioural reference state
    int m_valid = 0, m_mode = 0, m_primed = 0, m_cur = 0, m_done = 0, m_phase = 0;
    logic [W-1:0] m_lfsr = 16'h0001;

    task automatic check(input string what, input longint got, input longint exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic longint exp_data();
        case (m_mode)
            0: return const_val;
            1: return m_cur;
            2: return (m_phase < int'(high_cnt)) ? pulse_val : 0;
            3: return m_lfsr;
            4: return (m_phase >= int'(rise_at) && m_phase < int'(fall_at)) ? 16'hFFFF : 0;
            default: return 0;
        endcase
    endfunction

    task automatic model_edge();
        int nx;
        if (en) begin
            if (!m_primed || int'(mode) != m_mode) begin
                m_primed = 1;
                m_mode   = mode;
                m_cur    = ramp_from;
                m_done   = (ramp_from == ramp_to);
                m_phase  = 0;
                m_lfsr   = (seed == 0) ? 16'h0001 : seed;
            end else begin
                if (!m_done) begin
                    if (ramp_down) begin
                        nx = m_cur - int'(ramp_step);
                        if (nx <= int'(ramp_to)) nx = ramp_to;
                    end else begin
                        nx = m_cur + int'(ramp_step);
                        if (nx >= int'(ramp_to)) nx = ramp_to;
                    end
                    m_cur  = nx;
                    m_done = (nx == int'(ramp_to));
                end
                m_phase = (m_phase + 1 >= int'(period)) ? 0 : m_phase + 1;
                m_lfsr  = (m_lfsr >> 1) ^ (m_lfsr[0] ? 16'hB400 : 16'h0000);
            end
        end
        m_valid = en;
    endtask

    task automatic cyc(input logic e);
        en = e;
        @(posedge clk);
        model_edge();
        #1;
        check("out_valid", out_valid, m_valid);
        check("out_data", out_data, exp_data());
        check("ramp_done", ramp_done, (m_done != 0 && m_mode == 1));
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; mode = 3'd0; ramp_down = 1'b0;
        const_val = 16'h55AA; ramp_from = 0; ramp_to = 0; ramp_step = 0;
        pulse_val = 0; seed = 0; period = 0; high_cnt = 0; rise_at = 0; fall_at = 0;
        repeat (3) @(posedge clk);
        #1;
        req = "R1";
        check("out_valid in reset", out_valid, 0);
        check("ramp_done in reset", ramp_done, 0);
        rst_n = 1'b1;
        cyc(1'b0);

        // R3 constant follows live input
        req = "R3";
        cyc(1'b1);
        const_val = 16'h1234;
        cyc(1'b1); cyc(1'b1);

        // R2 valid follows enable
        req = "R2";
        cyc(1'b0); cyc(1'b1); cyc(1'b0); cyc(1'b0); cyc(1'b1);

        // R4 ramp up, R5 clamp, with a stall (R11)
        req = "R4";
        mode = 3'd1; ramp_from = 10; ramp_to = 40; ramp_step = 7; ramp_down = 1'b0;
        cyc(1'b1); cyc(1'b1); cyc(1'b1);
        req = "R11";
        cyc(1'b0); cyc(1'b0);
        req = "R5";
        cyc(1'b1); cyc(1'b1); cyc(1'b1); cyc(1'b1); cyc(1'b1);

        // R6 ramp down with clamp
        req = "R6";
        mode = 3'd0; cyc(1'b1);
        mode = 3'd1; ramp_from = 100; ramp_to = 5; ramp_step = 30; ramp_down = 1'b1;
        repeat (6) cyc(1'b1);
        // borrow clamp
        mode = 3'd0; cyc(1'b1);
        mode = 3'd1; ramp_from = 20; ramp_to = 2; ramp_step = 16'hFFF0;
        repeat (3) cyc(1'b1);

        // R5 overflow clamp going up
        req = "R5";
        mode = 3'd0; cyc(1'b1);
        mode = 3'd1; ramp_from = 16'hFFF0; ramp_to = 16'hFFFF; ramp_step = 16'h0020;
        ramp_down = 1'b0;
        repeat (3) cyc(1'b1);

        // R7 pulse
        req = "R7";
        mode = 3'd2; period = 5; high_cnt = 2; pulse_val = 16'hBEEF;
        repeat (12) cyc(1'b1);
        mode = 3'd0; cyc(1'b1);
        mode = 3'd2; period = 0; high_cnt = 1;
        repeat (3) cyc(1'b1);

        // R8 random from a seed
        req = "R8";
        mode = 3'd3; seed = 16'h1234;
        repeat (10) cyc(1'b1);

        // R11 mode change without enable has no effect yet
        req = "R11";
        mode = 3'd1; ramp_from = 16'h0300; ramp_to = 16'h0400; ramp_step = 16'h0100;
        cyc(1'b0); cyc(1'b0);
        cyc(1'b1); cyc(1'b1);

        // R9 zero seed
        req = "R9";
        mode = 3'd3; seed = 16'h0000;
        repeat (6) cyc(1'b1);

        // R10 clock-like pattern
        req = "R10";
        mode = 3'd4; period = 6; rise_at = 2; fall_at = 5;
        repeat (14) cyc(1'b1);

        // R12 unused codes
        req = "R12";
        mode = 3'd6; cyc(1'b1); cyc(1'b1);
        mode = 3'd7; cyc(1'b1);
        mode = 3'd5; cyc(1'b1); cyc(1'b0);

        finish_run();
    end

endmodule